// File: doc/BRIEF.md
# Serial 0011 Pattern Detector

The block watches a serial bit stream and takes one bit on each rising clock edge. Its output `hit_out` rises in the same cycle as the fourth bit of the pattern 0, 0, 1, 1 (oldest bit first). The output is combinational from the stored state and the present input bit. A match may reuse zeros that were seen before, so a longer run of zeros in front of "11" still counts as a match. Each bit of the stream is sampled only once.

There are four states in a two-bit register, and the state is visible on `state_out`. The high state bit is held in a JK flip-flop. Its J and K inputs come from explicit excitation logic. The low state bit is held in a D flip-flop. The parameter `FULL_J_TERM` selects one of two forms of the J equation. Both forms give the same behaviour.

Top module: `pat0011_detector`

## Requirements
- R1: When `rst` is high at a rising edge, the state becomes 2'b00 at that edge. While the state is 2'b00, `hit_out` is 0 for any `bit_in`.
- R2: The state on `state_out` records the useful suffix seen so far. 2'b00 means no prefix, 2'b01 means "0", 2'b10 means "00" and 2'b11 means "001".
- R3: From state 2'b00, a 0 moves to 2'b01 and a 1 stays at 2'b00. From state 2'b01, a 0 moves to 2'b10 and a 1 moves to 2'b00.
- R4: From state 2'b10, a 0 stays at 2'b10 and a 1 moves to 2'b11. From state 2'b11, a 0 moves to 2'b01 and a 1 moves to 2'b00.
- R5: `hit_out` is 1 exactly when the state is 2'b11 and `bit_in` is 1 in the same cycle, before the clock edge that takes the bit. This means it is 1 exactly when the last four bits, oldest first, are 0,0,1,1.
- R6: Matches may overlap earlier zeros. After reset, the stream 0,0,0,1,1 raises `hit_out` on the fifth bit. A 0 that follows a match leads to state 2'b01.
- R7: State bit 1 is held in a JK flip-flop on the rising edge. J=K=0 holds the bit, J=1,K=0 sets it, J=0,K=1 clears it and J=K=1 toggles it. J = S0 & ~bit_in and K = S0.
- R8: State bit 0 is held in a D flip-flop on the rising edge. Its D input is 1 only for these three cases: state 00 with bit 0, state 10 with bit 1, and state 11 with bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial input bit, one per cycle |
| hit_out | output | 1 | High in the cycle that completes 0,0,1,1 |
| state_out | output | 2 | Present state {S1,S0} |

## Verification
The assertions assume that `bit_in` and `rst` are stable and known around each rising edge. They also assume that `rst` is high at the first edge, so the state starts from a known value. The bench changes inputs only on the falling edge. It holds reset through the first edges, and it reapplies reset in the middle of the stream only on a falling edge.

// File: rtl/pat0011_pkg.sv
package pat0011_pkg;
   localparam int STATE_W = 2;

   typedef enum logic [STATE_W-1:0] {
      SEEN_NONE = 2'b00,
      SEEN_0    = 2'b01,
      SEEN_00   = 2'b10,
      SEEN_001  = 2'b11
   } seq_state_e;

   localparam logic [STATE_W-1:0] RESET_STATE = SEEN_NONE;
endpackage

// File: rtl/pat0011_jk_ff.sv
module pat0011_jk_ff #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic j,
   input  logic k,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= RST_VAL;
      end else begin
         unique case ({j, k})
            2'b00:   q <= q;
            2'b01:   q <= 1'b0;
            2'b10:   q <= 1'b1;
            default: q <= ~q;
         endcase
      end
   end

   // R7
   jk_set_chk: assert property (@(posedge clk) disable iff (rst)
      (j && !k) |=> q);
   // R7
   jk_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (!j && k) |=> !q);
   // R7
   jk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
      (j && k) |=> (q != $past(q)));
   // R7
   jk_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!j && !k) |=> $stable(q));
endmodule

// File: rtl/pat0011_d_ff.sv
module pat0011_d_ff #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else     q <= d;
   end

   // R8
   d_follow_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (q == $past(d)));
endmodule

// File: rtl/pat0011_excite.sv
module pat0011_excite #(
   parameter int FULL_J_TERM = 0
) (
   input  logic s1,
   input  logic s0,
   input  logic bit_i,
   output logic j1,
   output logic k1,
   output logic d0,
   output logic hit
);
   generate
      if (FULL_J_TERM != 0 && FULL_J_TERM != 1) begin : g_bad_param
         $error("FULL_J_TERM must be 0 or 1");
      end
      if (FULL_J_TERM == 1) begin : g_j_full
         assign j1 = ~s1 & s0 & ~bit_i;
      end else begin : g_j_min
         assign j1 = s0 & ~bit_i;
      end
   endgenerate

   assign k1  = s0;
   assign d0  = (~s1 & ~s0 & ~bit_i) | (s1 & ~s0 & bit_i) | (s1 & s0 & ~bit_i);
   assign hit = s1 & s0 & bit_i;

   // R8
   always_comb begin
      d0_range_chk: assert (!(d0 && s0 && !s1)) else $error("d0 set from state 01");
   end
endmodule

// File: rtl/pat0011_detector.sv
module pat0011_detector
   import pat0011_pkg::*;
#(
   parameter int FULL_J_TERM = 0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       bit_in,
   output logic       hit_out,
   output logic [1:0] state_out
);
   logic s1_q, s0_q;
   logic j1, k1, d0, hit_c;

   generate
      if (STATE_W != 2) begin : g_bad_width
         $error("state register must be two bits");
      end
   endgenerate

   pat0011_excite #(.FULL_J_TERM(FULL_J_TERM)) u_excite (
      .s1(s1_q), .s0(s0_q), .bit_i(bit_in),
      .j1(j1), .k1(k1), .d0(d0), .hit(hit_c)
   );

   pat0011_jk_ff #(.RST_VAL(RESET_STATE[1])) u_s1_jk (
      .clk(clk), .rst(rst), .j(j1), .k(k1), .q(s1_q)
   );

   pat0011_d_ff #(.RST_VAL(RESET_STATE[0])) u_s0_d (
      .clk(clk), .rst(rst), .d(d0), .q(s0_q)
   );

   assign state_out = {s1_q, s0_q};
   assign hit_out   = hit_c;

   // R1
   reset_idle_chk: assert property (@(posedge clk) rst |=> (state_out == SEEN_NONE));
   // R5
   hit_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
      hit_out |=> (state_out == SEEN_NONE));
   // R4
   zz_one_chk: assert property (@(posedge clk) disable iff (rst)
      (state_out == SEEN_00 && bit_in) |=> (state_out == SEEN_001));
   // R6
   zero_after_match_chk: assert property (@(posedge clk) disable iff (rst)
      (state_out == SEEN_001 && !bit_in) |=> (state_out == SEEN_0));
   // R5
   no_double_hit_chk: assert property (@(posedge clk) disable iff (rst)
      hit_out |=> !hit_out);
endmodule

// File: tb/pat0011_detector_bench.sv
module pat0011_detector_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bit_in = 1'b0;
   logic       hit_out;
   logic [1:0] state_out;

   int n_run  = 0;
   int n_fail = 0;
   bit hist[$];

   pat0011_detector u_pat0011_detector (
      .clk(clk), .rst(rst), .bit_in(bit_in),
      .hit_out(hit_out), .state_out(state_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [1:0] exp_state();
      int n = hist.size();
      if (n >= 3 && hist[n-3] == 0 && hist[n-2] == 0 && hist[n-1] == 1) return 2'b11;
      if (n >= 2 && hist[n-2] == 0 && hist[n-1] == 0) return 2'b10;
      if (n >= 1 && hist[n-1] == 0) return 2'b01;
      return 2'b00;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      hist.delete();
      check(state_out == 2'b00, "R1 state", state_out, 0);
      bit_in = 1'b1; #1;
      check(hit_out == 1'b0, "R1 hit", hit_out, 0);
      rst = 1'b0;
   endtask

   task automatic step(input bit b, input string hit_tag);
      logic [1:0] es;
      bit eh;
      @(negedge clk);
      bit_in = b;
      #1;
      es = exp_state();
      eh = (es == 2'b11) && b;
      check(state_out == es, (es[1] ? "R4 state" : "R3 state"), state_out, es);
      check(hit_out == eh, hit_tag, hit_out, eh);
      hist.push_back(b);
      if (hist.size() > 8) void'(hist.pop_front());
      @(posedge clk); #1;
      es = exp_state();
      check(state_out[1] == es[1], "R7 jk bit", state_out[1], es[1]);
      check(state_out[0] == es[0], "R8 d bit", state_out[0], es[0]);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      // R2: state meanings
      step(0, "R5 hit");
      check(state_out == 2'b01, "R2 after 0", state_out, 1);
      step(0, "R5 hit");
      check(state_out == 2'b10, "R2 after 00", state_out, 2);
      step(1, "R5 hit");
      check(state_out == 2'b11, "R2 after 001", state_out, 3);
      step(1, "R5 hit");
      check(state_out == 2'b00, "R2 after match", state_out, 0);

      // R6: overlapping zeros, then 0 after a match
      do_reset();
      step(0, "R6 hit"); step(0, "R6 hit"); step(0, "R6 hit"); step(1, "R6 hit");
      @(negedge clk); bit_in = 1'b1; #1;
      check(hit_out == 1'b1, "R6 fifth bit", hit_out, 1);
      hist.push_back(1'b1);
      @(posedge clk); #1;
      step(0, "R6 hit");
      do_reset();
      step(0, "R6 hit"); step(0, "R6 hit"); step(1, "R6 hit"); step(1, "R6 hit");
      step(0, "R6 hit");
      check(state_out == 2'b01, "R6 zero after match", state_out, 1);

      // R1: reset in the middle of a near match
      step(0, "R5 hit"); step(1, "R5 hit");
      do_reset();
      step(1, "R1 hit after reset");

      // R3/R4: repeated patterns and random stream
      for (int r = 0; r < 20; r++) begin
         step(0, "R5 hit"); step(0, "R5 hit"); step(1, "R5 hit"); step(1, "R5 hit");
      end
      for (int r = 0; r < 3000; r++) begin
         step(bit'($urandom_range(0, 1)), "R5 hit");
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule